// File: doc/BRIEF.md
# Line Interface Power Mode Controller

This block holds the powerdown control bits of a telephone line interface and turns them into one of three power states: normal, sleep and deep sleep. From that state it drives enables for the line-side domain, the ring-detect output path and the digital link domain. A host programs the control bits through a simple write port with a write enable, an address and a data byte.

Both powerdown states are one-way. Once one of them is entered, a register write cannot bring the block back to normal. Only a low pulse on the active-low reset input does that, and the pulse also restores the register default. During sleep the frame clock must keep running. The block watches that clock and raises a sticky error flag if it stalls.

Top module: `lif_power_ctrl`

## Requirements
- R1: After a low pulse on `rst_n`, `pwr_state` is 00 (normal), the power register holds its default with the line-side powerdown bit set, `line_en` is 0, `ring_en` and `link_en` are 1, and `clk_err` is 0.
- R2: The power register is at address 6. Bit 4 is the line-side powerdown bit and bit 3 is the system powerdown bit. In normal, `line_en` is 1 exactly when bit 4 is clear.
- R3: A write to any address other than the power register has no effect on the state or the enables.
- R4: A write that sets bit 3 while bit 4 is clear moves normal to sleep (`pwr_state` 01) at that clock edge. Sleep gives `line_en` 0, `ring_en` 1 and `link_en` 1.
- R5: A write that sets bits 3 and 4 together moves normal to deep sleep (`pwr_state` 10). Deep sleep drives all three enables and `ring_out` to 0.
- R6: A write that clears bit 3 or bit 4 does not leave sleep or deep sleep.
- R7: Only a low pulse on `rst_n` leaves a powerdown state. The block then returns to normal with the register default.
- R8: `ring_out` equals `ring_raw` while `ring_en` is 1 and is 0 otherwise.
- R9: In sleep, a write that leaves bits 3 and 4 both set moves the block to deep sleep.
- R10: In sleep, if `fclk` shows no edge for more than 16 consecutive system clocks, `clk_err` goes to 1 within a few further clocks, which is the synchroniser delay. A stalled `fclk` in normal never raises `clk_err`.
- R11: `clk_err` is sticky. It stays 1 after `fclk` resumes, and only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the only way out of powerdown |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| fclk | input | 1 | Frame clock, asynchronous to `clk` |
| ring_raw | input | 1 | Ring indication from the detector |
| ring_out | output | 1 | Gated ring-detect output |
| line_en | output | 1 | Line-side domain enable |
| ring_en | output | 1 | Ring-detect path enable |
| link_en | output | 1 | Digital link domain enable |
| pwr_state | output | 2 | 00 normal, 01 sleep, 10 deep sleep |
| clk_err | output | 1 | Sticky frame-clock stall flag |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 5-bit address, the register at address 6 and a stall limit of 16. A 16-clock limit lets the bench make one short frame-clock gap and one long one within a few dozen cycles, which tests both sides of the threshold. The bench also drives every path into and out of the powerdown states, including deepening from sleep and clearing bits after entry, through the same write port a host would use.

// File: rtl/lif_power_ctrl.sv
module lif_power_ctrl #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int PWR_ADDR    = 6,
  parameter int LINE_PD_BIT = 4,
  parameter int SYS_PD_BIT  = 3,
  parameter int CLK_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fclk,
  input  logic              ring_raw,
  output logic              ring_out,
  output logic              line_en,
  output logic              ring_en,
  output logic              link_en,
  output logic [1:0]        pwr_state,
  output logic              clk_err
);
  localparam logic [1:0] ST_NORM  = 2'b00;
  localparam logic [1:0] ST_SLEEP = 2'b01;
  localparam logic [1:0] ST_DEEP  = 2'b10;
  localparam logic [DATA_W-1:0] CTRL_DEF = DATA_W'(1) << LINE_PD_BIT;
  localparam int CW = $clog2(CLK_TIMEOUT + 2);

  logic [DATA_W-1:0] ctrl_q, ctrl_nx;
  logic [1:0]        st_q;
  logic [2:0]        fsync_q;
  logic [CW-1:0]     idle_q;
  logic              fedge;

  assign ctrl_nx = (wr_en && wr_addr == ADDR_W'(PWR_ADDR)) ? wr_data : ctrl_q;
  assign fedge   = fsync_q[2] ^ fsync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      st_q   <= ST_NORM;
    end else begin
      ctrl_q <= ctrl_nx;
      case (st_q)
        ST_NORM:
          if (ctrl_nx[SYS_PD_BIT])
            st_q <= ctrl_nx[LINE_PD_BIT] ? ST_DEEP : ST_SLEEP;
        ST_SLEEP:
          if (ctrl_nx[SYS_PD_BIT] && ctrl_nx[LINE_PD_BIT])
            st_q <= ST_DEEP;
        default: st_q <= st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q <= '0;
      idle_q  <= '0;
      clk_err <= 1'b0;
    end else begin
      fsync_q <= {fsync_q[1:0], fclk};
      if (fedge || st_q != ST_SLEEP)
        idle_q <= '0;
      else if (idle_q != CW'(CLK_TIMEOUT + 1))
        idle_q <= idle_q + 1'b1;
      if (st_q == ST_SLEEP && !fedge && idle_q >= CW'(CLK_TIMEOUT))
        clk_err <= 1'b1;
    end
  end

  assign pwr_state = st_q;
  assign line_en   = (st_q == ST_NORM) && !ctrl_q[LINE_PD_BIT];
  assign ring_en   = (st_q != ST_DEEP);
  assign link_en   = (st_q != ST_DEEP);
  assign ring_out  = ring_raw & ring_en;
endmodule

module lif_power_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ring_raw,
  input logic       ring_out,
  input logic       line_en,
  input logic       ring_en,
  input logic       link_en,
  input logic [1:0] pwr_state,
  input logic       clk_err
);
  p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);
  p_sleep_paths_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b01 |-> (ring_en && link_en && !line_en));
  p_deep_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b10 |-> (!ring_en && !link_en && !line_en && !ring_out));
  p_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b00 |=> pwr_state != 2'b00);
  p_ring_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out |-> (ring_raw && ring_en));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |=> clk_err);
  p_err_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |-> $past(pwr_state) == 2'b01);
endmodule

bind lif_power_ctrl lif_power_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_raw(ring_raw), .ring_out(ring_out),
  .line_en(line_en), .ring_en(ring_en), .link_en(link_en),
  .pwr_state(pwr_state), .clk_err(clk_err)
);

// File: tb/lif_power_ctrl_bench.sv
module lif_power_ctrl_bench;
  typedef struct {
    string      tag;
    logic [1:0] st;
    logic       line, ring, link, err, rout;
  } exp_t;

  logic clk = 0, rst_n = 0, wr_en = 0, fclk = 0, ring_raw = 0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ring_out, line_en, ring_en, link_en, clk_err;
  logic [1:0] pwr_state;
  logic fclk_run = 1;
  bit   done = 0;
  int   checks = 0, errors = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lif_power_ctrl u_lif_power_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fclk(fclk), .ring_raw(ring_raw), .ring_out(ring_out), .line_en(line_en),
    .ring_en(ring_en), .link_en(link_en), .pwr_state(pwr_state), .clk_err(clk_err)
  );

  initial forever begin
    @(negedge clk); @(negedge clk);
    if (fclk_run) fclk = ~fclk;
  end

  initial forever begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwr_state !== e.st || line_en !== e.line || ring_en !== e.ring ||
          link_en !== e.link || clk_err !== e.err || ring_out !== e.rout) begin
        errors++;
        $display("FAIL %s: got st=%b line=%b ring=%b link=%b err=%b rout=%b exp st=%b line=%b ring=%b link=%b err=%b rout=%b",
          e.tag, pwr_state, line_en, ring_en, link_en, clk_err, ring_out,
          e.st, e.line, e.ring, e.link, e.err, e.rout);
      end
    end
  end

  task automatic expect_now(string tag, logic [1:0] st, logic line, logic ring,
                            logic link, logic err, logic rout);
    exp_t e;
    e.tag = tag; e.st = st; e.line = line; e.ring = ring;
    e.link = link; e.err = err; e.rout = rout;
    q.push_back(e);
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    pulse_reset();
    expect_now("R1 reset state", 2'b00, 0, 1, 1, 0, 0);
    ring_raw = 1; idle(1);
    expect_now("R8 ring passes in normal", 2'b00, 0, 1, 1, 0, 1);
    wr(5'd5, 8'h08); idle(1);
    expect_now("R3 other address ignored", 2'b00, 0, 1, 1, 0, 1);
    wr(5'd6, 8'h00); idle(1);
    expect_now("R2 line powerdown cleared", 2'b00, 1, 1, 1, 0, 1);
    wr(5'd6, 8'h08); idle(1);
    expect_now("R4 enter sleep", 2'b01, 0, 1, 1, 0, 1);
    wr(5'd6, 8'h00); idle(1);
    expect_now("R6 clear bits keep sleep", 2'b01, 0, 1, 1, 0, 1);
    fclk_run = 0; idle(8); fclk_run = 1; idle(6);
    expect_now("R10 short stall no error", 2'b01, 0, 1, 1, 0, 1);
    fclk_run = 0; idle(40);
    expect_now("R10 long stall error", 2'b01, 0, 1, 1, 1, 1);
    fclk_run = 1; idle(10);
    expect_now("R11 error sticky", 2'b01, 0, 1, 1, 1, 1);
    pulse_reset();
    expect_now("R7 reset exits sleep", 2'b00, 0, 1, 1, 0, 1);
    wr(5'd6, 8'h18); idle(1);
    expect_now("R5 enter deep sleep", 2'b10, 0, 0, 0, 0, 0);
    wr(5'd6, 8'h00); idle(1);
    expect_now("R6 clear bits keep deep", 2'b10, 0, 0, 0, 0, 0);
    pulse_reset();
    expect_now("R7 reset exits deep", 2'b00, 0, 1, 1, 0, 1);
    wr(5'd6, 8'h08); idle(1);
    expect_now("R9 sleep before deepen", 2'b01, 0, 1, 1, 0, 1);
    wr(5'd6, 8'h18); idle(1);
    expect_now("R9 sleep deepens", 2'b10, 0, 0, 0, 0, 0);
    pulse_reset();
    wr(5'd6, 8'h00);
    fclk_run = 0; idle(40);
    expect_now("R10 stall in normal ignored", 2'b00, 1, 1, 1, 0, 1);
    fclk_run = 1;
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule